// File: doc/BRIEF.md
# Pointer-Addressed Word Register Slave for a Temperature Sensor

This block is the two-wire serial slave that stands in front of the register set of an on-chip temperature sensor. The set has nine 16-bit words. An 8-bit pointer selects the word. The pointer is loaded by the first byte after a write-direction address. It stays latched between transactions, so a master that polls the same word can send only a read-direction address each time.

A write transaction has four parts: the address, the pointer byte, the high data byte and the low data byte. If the master stops after the pointer byte, the pointer is preset and no word is written. If it sends a repeated START with a read-direction address instead, the result is a random word read. A read returns the high byte first and then the low byte. All bytes are sent most significant bit first. After the low byte the master may answer with either ACK or NoACK.

The sensor core refreshes the temperature word through a parallel load strobe. Temperature conversion itself is done elsewhere.

Top module: `tsreg_i2c_slave`

## Requirements
- R1: The slave responds only to the 7-bit address formed from the fixed prefix 4'b0011 followed by `sel_pins[2:0]`. The direction bit follows the address: 0 means write and 1 means read. Any other address gets no acknowledge, and the transaction has no effect on the pointer or on any register.
- R2: A write made of address(W), pointer, high byte and low byte stores {high, low} into the addressed word. This applies to the writable pointers 1, 2, 3, 4 and 8, which reset to 16'h0000. The slave acknowledges each of the four bytes.
- R3: A read returns the selected word as two bytes, high byte first, each byte most significant bit first. The slave changes SDA only while SCL is low.
- R4: The pointer keeps its value between transactions. A write that stops after the pointer byte only loads the pointer. A read with no pointer byte uses the latched pointer, and repeated reads return the same word.
- R5: A pointer write followed by a repeated START and address(R) returns the word at the new pointer.
- R6: After the low byte of a read, the slave accepts either ACK or NoACK and releases SDA. If the master sends NoACK after the high byte, the read ends and the low byte is not driven. In every case the next transaction works normally.
- R7: A pointer value above 8 is acknowledged. Reads at such a pointer return 16'h0000, and writes there are discarded.
- R8: The following words are read-only and ignore written data: pointer 0 (capability, 16'h0057), pointer 6 (16'hA5C3), pointer 7 (16'h0102) and pointer 5 (temperature).
- R9: A one-cycle pulse on `temp_we` loads `temp_data` into the temperature word at pointer 5. It is visible to the next read.
- R10: After reset the pointer is 0, the temperature word is 16'h0000 and `sda_oe` is 0.
- R11: A data byte after the low byte is not acknowledged and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| sel_pins | input | 3 | Low three bits of the slave address |
| temp_we | input | 1 | Load strobe for the temperature word |
| temp_data | input | 16 | New temperature value |

## Verification
The pointer-and-word path is driven by a random mix of five operations: full writes, pointer-only presets, current-pointer reads, random reads and sensor loads. The pointers are drawn from 0 to 11, so each run covers writable, read-only and unmapped words. A wrong value reaching one pointer but not another shows up as a mismatch against the bench model. A stale pointer after a preset shows up the same way, as does a write reaching a protected word.

Directed cases cover behaviour that random traffic rarely produces: the reset contents, a foreign address, NoACK after the high byte against ACK after the low byte, and an extra third data byte. Words with distinct high and low bytes tell swapped byte order or bit order apart from correct transfer.

// File: rtl/tsreg_pkg.sv
// Package: shared constants and state types for the pointer-addressed
// register slave. Assumes a 7-bit bus address with a fixed upper nibble.
package tsreg_pkg;
    localparam int PTR_W  = 8;
    localparam int WORD_W = 16;
    localparam logic [3:0] ADDR_PREFIX = 4'b0011;

    // Link layer phase of the bus protocol engine.
    typedef enum logic [2:0] {
        LK_IDLE, LK_RX, LK_RX_ACK, LK_TX, LK_TX_ACK
    } link_st_t;

    // Role of the next received byte inside a transaction.
    typedef enum logic [2:0] {
        BY_ADDR, BY_PTR, BY_HIGH, BY_LOW, BY_EXTRA
    } byte_role_t;
endpackage

// File: rtl/tsreg_bus_sense.sv
// Module: synchronises SCL/SDA into the clock domain and flags edges,
// START and STOP. Assumes clk is several times faster than SCL.
module tsreg_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_m, sda_m, scl_d, sda_d;

    // Two-flop synchronisers plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1; sda_m <= 1'b1;
            scl_s <= 1'b1; sda_s <= 1'b1;
            scl_d <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i; sda_m <= sda_i;
            scl_s <= scl_m; sda_s <= sda_m;
            scl_d <= scl_s; sda_d <= sda_s;
        end
    end

    // Event decode: data edges while the clock stays high are bus conditions.
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/tsreg_bank.sv
// Module: nine-word register set. Writable words take bus writes,
// the temperature word loads from the sensor port, others are constants.
// Assumes pointers at or above NUM_REGS read as zero.
module tsreg_bank #(
    parameter int NUM_REGS = 9,
    parameter int DW = 16,
    parameter int PW = 8,
    parameter int TEMP_IDX = 5,
    parameter logic [NUM_REGS-1:0] RW_MASK = 9'b1_0001_1110,
    parameter logic [DW-1:0] CAP_VAL = 16'h0057,
    parameter logic [DW-1:0] ID_A_VAL = 16'hA5C3,
    parameter logic [DW-1:0] ID_B_VAL = 16'h0102
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [DW-1:0] rd_data,
    input  logic          temp_we,
    input  logic [DW-1:0] temp_in,
    output logic [DW-1:0] temp_q
);
    logic [DW-1:0] rd_vec [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        logic [DW-1:0] q;
        if (i == TEMP_IDX) begin : g_temp
            // Temperature word: loaded only from the sensor side.
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (temp_we) q <= temp_in;
            end
        end else if (RW_MASK[i]) begin : g_rw
            // Writable word: takes a completed bus write at its pointer.
            always_ff @(posedge clk) begin
                if (!rst_n)                               q <= '0;
                else if (wr_en && wr_ptr == PW'(i))       q <= wr_data;
            end
        end else begin : g_ro
            assign q = (i == 0) ? CAP_VAL : (i == 6) ? ID_A_VAL :
                       (i == 7) ? ID_B_VAL : '0;
        end
        assign rd_vec[i] = q;
    end

    assign temp_q = rd_vec[TEMP_IDX];

    // Read select: unmapped pointers fall through to zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_ptr == PW'(i)) rd_data = rd_vec[i];
    end
endmodule

// File: rtl/tsreg_link.sv
// Module: byte-level slave protocol engine. Decodes address, pointer and
// data bytes, drives ACK and read data on SDA via an open-drain enable.
// Assumes SCL edges are at least a few clk cycles apart.
module tsreg_link
    import tsreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data
);
    link_st_t          st;
    byte_role_t        role;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        hi_q;
    logic [WORD_W-1:0] word_q;
    logic              go_tx, lo_phase, mack;

    // Protocol sequencing: one process owns all link state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LK_IDLE; role <= BY_ADDR; bitcnt <= '0; sh <= '0;
            hi_q <= '0; word_q <= '0; go_tx <= 1'b0; lo_phase <= 1'b0;
            mack <= 1'b0; sda_oe <= 1'b0; ptr_q <= '0;
            wr_en <= 1'b0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_ev) begin
                st <= LK_IDLE; sda_oe <= 1'b0;
            end else if (start_ev) begin
                st <= LK_RX; role <= BY_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
            end else begin
                case (st)
                    LK_RX: begin
                        if (scl_rise) begin
                            sh <= {sh[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            st <= LK_RX_ACK;
                            sda_oe <= 1'b1;
                            go_tx <= 1'b0;
                            case (role)
                                BY_ADDR: begin
                                    if (sh[7:1] == {ADDR_PREFIX, sel}) begin
                                        go_tx <= sh[0];
                                        word_q <= rd_data;
                                        role <= BY_PTR;
                                    end else begin
                                        st <= LK_IDLE; sda_oe <= 1'b0;
                                    end
                                end
                                BY_PTR:  begin ptr_q <= sh; role <= BY_HIGH; end
                                BY_HIGH: begin hi_q <= sh; role <= BY_LOW; end
                                BY_LOW: begin
                                    wr_en <= 1'b1;
                                    wr_data <= {hi_q, sh};
                                    role <= BY_EXTRA;
                                end
                                default: begin st <= LK_IDLE; sda_oe <= 1'b0; end
                            endcase
                        end
                    end
                    LK_RX_ACK: begin
                        if (scl_fall) begin
                            if (go_tx) begin
                                st <= LK_TX; sh <= word_q[15:8];
                                sda_oe <= ~word_q[15]; lo_phase <= 1'b0;
                            end else begin
                                st <= LK_RX; sda_oe <= 1'b0;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0; st <= LK_TX_ACK; bitcnt <= '0;
                            end else begin
                                sh <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    LK_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        else if (scl_fall) begin
                            if (!lo_phase && mack) begin
                                st <= LK_TX; sh <= word_q[7:0];
                                sda_oe <= ~word_q[7]; lo_phase <= 1'b1;
                            end else begin
                                st <= LK_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsreg_i2c_slave.sv
// Module: top of the pointer-addressed word register slave. Joins the
// bus front end, the protocol engine and the register set.
// Assumes an external open-drain pad: sda_oe=1 pulls SDA low.
module tsreg_i2c_slave
    import tsreg_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int TEMP_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        sel_pins,
    input  logic              temp_we,
    input  logic [WORD_W-1:0] temp_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [PTR_W-1:0]  ptr_q;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data, rd_data, temp_q;

    tsreg_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tsreg_link u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .sel(sel_pins), .rd_data(rd_data), .sda_oe(sda_oe),
        .ptr_q(ptr_q), .wr_en(wr_en), .wr_data(wr_data)
    );

    tsreg_bank #(
        .NUM_REGS(NUM_REGS), .DW(WORD_W), .PW(PTR_W), .TEMP_IDX(TEMP_IDX)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr_q),
        .wr_data(wr_data), .rd_ptr(ptr_q), .rd_data(rd_data),
        .temp_we(temp_we), .temp_in(temp_data), .temp_q(temp_q)
    );
endmodule

// File: rtl/tsreg_chk.sv
// Module: assertion checker for the register slave, bound to the top.
// Assumes the bound signals come from separate pieces of logic.
module tsreg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_s,
    input logic        scl_fall,
    input logic        stop_ev,
    input logic [7:0]  ptr_q,
    input logic [15:0] rd_data,
    input logic        temp_we,
    input logic [15:0] temp_data,
    input logic [15:0] temp_q
);
    AST_OE_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);                                  // R3
    AST_PTR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> $past(scl_fall));                       // R4
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);                                       // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q > 8'd8) |-> (rd_data == 16'h0000));                  // R7
    AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        temp_we |=> (temp_q == $past(temp_data)));                  // R9
endmodule

bind tsreg_i2c_slave tsreg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .scl_fall(scl_fall), .stop_ev(stop_ev), .ptr_q(ptr_q),
    .rd_data(rd_data), .temp_we(temp_we), .temp_data(temp_data),
    .temp_q(temp_q)
);

// File: tb/sim_tsreg_i2c_slave.sv
module sim_tsreg_i2c_slave;
    localparam int Q = 6;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic [2:0] sel = 3'b010;
    logic temp_we = 1'b0;
    logic [15:0] temp_data = '0;
    wire  sda_oe;
    wire  sda_line = sda_m & ~sda_oe;
    int n_chk = 0, n_bad = 0;
    logic [15:0] model [0:8];
    logic [7:0]  mptr;

    always #2.5 clk = ~clk;

    tsreg_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sel_pins(sel), .temp_we(temp_we),
        .temp_data(temp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] p);
        return (p <= 8'd8) ? model[p[3:0]] : 16'h0000;
    endfunction

    function automatic bit writable(input logic [7:0] p);
        return p == 8'd1 || p == 8'd2 || p == 8'd3 || p == 8'd4 || p == 8'd8;
    endfunction

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
        end
        sda_m = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] adr(input bit rd);
        return {4'b0011, sel, rd};
    endfunction

    task automatic do_write(input logic [7:0] p, input logic [15:0] d, input string req);
        bit a0, a1, a2, a3;
        bus_start(); wbyte(adr(0), a0); wbyte(p, a1); wbyte(d[15:8], a2); wbyte(d[7:0], a3);
        bus_stop();
        chk(a0 && a1 && a2 && a3, req, {12'd0, a0, a1, a2, a3}, 16'h000F);
        mptr = p;
        if (writable(p)) model[p[3:0]] = d;
    endtask

    task automatic do_preset(input logic [7:0] p, input string req);
        bit a0, a1;
        bus_start(); wbyte(adr(0), a0); wbyte(p, a1); bus_stop();
        chk(a0 && a1, req, {14'd0, a0, a1}, 16'h0003);
        mptr = p;
    endtask

    task automatic do_cur_read(input bit lo_ack, input string req);
        bit a0; logic [7:0] h, l;
        bus_start(); wbyte(adr(1), a0); rbyte(1'b1, h); rbyte(lo_ack, l); bus_stop();
        chk(a0 && {h, l} == exp_rd(mptr), req, {h, l}, exp_rd(mptr));
    endtask

    task automatic do_rand_read(input logic [7:0] p, input string req);
        bit a0, a1, a2; logic [7:0] h, l;
        bus_start(); wbyte(adr(0), a0); wbyte(p, a1);
        bus_start(); wbyte(adr(1), a2); rbyte(1'b1, h); rbyte(1'b0, l); bus_stop();
        mptr = p;
        chk(a0 && a1 && a2 && {h, l} == exp_rd(p), req, {h, l}, exp_rd(p));
    endtask

    task automatic sensor_load(input logic [15:0] v);
        @(negedge clk); temp_we = 1'b1; temp_data = v;
        @(negedge clk); temp_we = 1'b0;
        model[5] = v;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit a; logic [7:0] h, l;
        void'($urandom(32'd2718));
        for (int i = 0; i <= 8; i++) model[i] = 16'h0000;
        model[0] = 16'h0057; model[6] = 16'hA5C3; model[7] = 16'h0102;
        mptr = 8'h00;
        repeat (4) @(negedge clk); rst_n = 1'b1; repeat (2) @(negedge clk);

        chk(sda_oe == 1'b0, "R10 oe after reset", {15'd0, sda_oe}, 16'h0);
        do_cur_read(1'b0, "R10 reset pointer reads capability R8");
        do_rand_read(8'd1, "R10 writable reset value");
        do_rand_read(8'd5, "R10 temperature reset value");

        do_write(8'd1, 16'hBE3C, "R2 write acks");
        do_rand_read(8'd1, "R5 random read R3 byte order");
        do_write(8'd3, 16'h8001, "R2 write ptr3");
        do_preset(8'd3, "R4 preset acks");
        do_cur_read(1'b1, "R4 reuse pointer R6 ack on low");
        do_cur_read(1'b0, "R4 repeated read");

        do_write(8'd6, 16'h1111, "R8 write acks on RO");
        do_rand_read(8'd6, "R8 RO word unchanged");
        do_write(8'd5, 16'h2222, "R8 write acks on temp");
        do_rand_read(8'd5, "R8 temp ignores bus write");
        sensor_load(16'h1A2B);
        do_cur_read(1'b0, "R9 temp from sensor port");

        do_write(8'h0A, 16'h3333, "R7 unmapped acked");
        do_cur_read(1'b0, "R7 unmapped reads zero");
        do_rand_read(8'd8, "R7 no alias to ptr8");

        // R1: foreign address, then matching address on new select pins.
        bus_start(); wbyte({4'b0011, ~sel, 1'b0}, a); wbyte(8'd2, h[0]); bus_stop();
        chk(a == 1'b0, "R1 foreign address NACK", {15'd0, a}, 16'h0);
        do_cur_read(1'b0, "R1 pointer untouched by foreign write");
        sel = 3'b101;
        do_write(8'd2, 16'h5AA5, "R1 new select pins accepted");
        do_rand_read(8'd2, "R1 data via new address");

        // R6: NoACK after high byte ends the read; bus stays usable.
        bus_start(); wbyte(adr(1), a); rbyte(1'b0, h); rbyte(1'b0, l); bus_stop();
        chk(h == 8'h5A && l == 8'hFF, "R6 NoACK after high byte", {h, l}, 16'h5AFF);
        do_cur_read(1'b1, "R6 next read after early NoACK");

        // R11: third data byte refused, word keeps the two-byte value.
        bus_start(); wbyte(adr(0), a); wbyte(8'd4, a); wbyte(8'hC3, a); wbyte(8'h3C, a);
        wbyte(8'h77, a); bus_stop();
        chk(a == 1'b0, "R11 extra byte NACK", {15'd0, a}, 16'h0);
        model[4] = 16'hC33C; mptr = 8'd4;
        do_cur_read(1'b0, "R11 word unchanged by extra byte");

        for (int k = 0; k < 36; k++) begin
            logic [7:0] p;
            p = 8'($urandom_range(0, 11));
            case ($urandom_range(0, 4))
                0: do_write(p, 16'($urandom), "R2 random write");
                1: do_preset(p, "R4 random preset");
                2: do_cur_read(1'($urandom), "R4 random current read R6");
                3: do_rand_read(p, "R5 random read R3");
                default: begin sensor_load(16'($urandom)); do_rand_read(8'd5, "R9 random sensor load"); end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule